// File: doc/BRIEF.md
# Bus Cycle Termination Controller

This block runs one external bus cycle at a time and decides how each cycle ends. After a cycle starts, the block watches four asynchronous inputs: the two-bit size acknowledge, an autovector acknowledge, a bus-error input and a halt input. An internal monitor timer runs alongside them. Each cycle ends in exactly one of four ways:

- normal completion with a port width,
- autovector completion, with a generated vector number,
- error,
- retry.

The block also drives the enables for the data bus, the strobes and the address-class outputs. It holds the bus while halt is asserted. While halted, it masks interrupt servicing.

Internal-only cycles complete on the next clock and take no part in halt. A flag for an external bus master turns off both the monitor and the autovector function. The block does not handle narrow-port operand splitting, chip-select decoding or the arbitration handshake.

Top module: `bus_term_ctrl`

## Requirements
- R1: While the external-master flag is clear, a cycle that gets no size acknowledge, no valid autovector and no bus error ends with `cyc_err` on the TIMEOUT-th clock after the clock that accepted `start`.
- R2: A bus error that arrives together with a size acknowledge ends the cycle with `cyc_err`. `cyc_done` stays low.
- R3: Halt and bus error seen together end the cycle with `cyc_retry` and hold the bus. Once halt is released, the same cycle runs again and can then complete normally.
- R4: Halt seen at the completion of a cycle gives single-step operation, and `halted` rises in the completion cycle. While halted, `data_oe` and `strobe_oe` are low and `addr_oe` is high. This state lasts until halt is released.
- R5: An internal cycle (`start` with `internal` high) returns `cyc_done` with `cyc_port16` on the next clock, whether or not the block is halted. It leaves `halted` unchanged.
- R6: `irq_mask` is high exactly while the block is halted.
- R7: `avec` ends only interrupt-acknowledge cycles and is ignored in all other cycle types. An autovector completion gives `cyc_done` and `cyc_avec`, plus a one-cycle `vec_valid` with `vec_num` = VEC_BASE + the interrupt level captured at start.
- R8: While `ext_master` is high, the monitor never times out and `avec` is ignored. Such a cycle ends only through a size acknowledge or a bus error.
- R9: Size acknowledge encoding: 2'b10 and 2'b11 mean a 16-bit port (`cyc_port16`=1), and 2'b01 means an 8-bit port (`cyc_port16`=0). Any nonzero value completes the cycle.
- R10: Every acknowledge, error and halt input passes through a two-flop synchronizer. An input applied together with `start` produces its outcome on the third clock edge.
- R11: After reset, all outcome strobes, `halted`, `irq_mask` and all drive enables are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a cycle |
| internal | input | 1 | Cycle stays on-chip |
| iack | input | 1 | Cycle is an interrupt acknowledge |
| int_level | input | 3 | Interrupt level being acknowledged |
| ext_master | input | 1 | External master owns the bus |
| size_ack | input | 2 | Size acknowledge pair, active high |
| avec | input | 1 | Autovector acknowledge |
| berr | input | 1 | External bus error |
| halt | input | 1 | Halt request |
| cyc_done | output | 1 | Normal completion strobe |
| cyc_port16 | output | 1 | Responding port is 16-bit |
| cyc_avec | output | 1 | Completion was by autovector |
| cyc_err | output | 1 | Error strobe |
| cyc_retry | output | 1 | Retry strobe |
| vec_valid | output | 1 | Generated vector valid |
| vec_num | output | 8 | Generated vector number |
| data_oe | output | 1 | Data bus drive enable |
| strobe_oe | output | 1 | Bus strobe drive enable |
| addr_oe | output | 1 | Address, function code, size and direction drive enable |
| halted | output | 1 | Bus held by halt |
| irq_mask | output | 1 | Interrupt servicing blocked |

## Verification
Halt can land in the same cycle as a bus error, and also in the same cycle as a normal acknowledge. The bench applies each pair at once with `start`. It then checks that the first pair yields a retry followed by a successful rerun, and that the second yields a completion followed by a held bus. A second overlap covers internal activity during halt: an internal cycle is issued while the bus is held, and the bench checks that it completes while `halted` stays high.

// File: rtl/bus_term_ctrl.sv
module bus_term_ctrl #(
  parameter int TIMEOUT  = 64,
  parameter int VEC_BASE = 24
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       internal,
  input  logic       iack,
  input  logic [2:0] int_level,
  input  logic       ext_master,
  input  logic [1:0] size_ack,
  input  logic       avec,
  input  logic       berr,
  input  logic       halt,
  output logic       cyc_done,
  output logic       cyc_port16,
  output logic       cyc_avec,
  output logic       cyc_err,
  output logic       cyc_retry,
  output logic       vec_valid,
  output logic [7:0] vec_num,
  output logic       data_oe,
  output logic       strobe_oe,
  output logic       addr_oe,
  output logic       halted,
  output logic       irq_mask
);
  localparam int CW = $clog2(TIMEOUT + 1);

  typedef enum logic [1:0] {IDLE, RUN, HOLD} st_t;
  st_t st;

  logic [1:0] ack_m, ack_s;
  logic [2:0] ctl_m, ctl_s;
  logic [CW-1:0] cnt;
  logic iack_r, rerun;
  logic [2:0] lvl_r;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ack_m <= '0; ack_s <= '0; ctl_m <= '0; ctl_s <= '0;
    end else begin
      ack_m <= size_ack; ack_s <= ack_m;
      ctl_m <= {avec, berr, halt}; ctl_s <= ctl_m;
    end

  wire s_avec   = ctl_s[2];
  wire s_berr   = ctl_s[1];
  wire s_halt   = ctl_s[0];
  wire timeout  = !ext_master && (cnt == CW'(TIMEOUT - 1));
  wire berr_eff = s_berr || timeout;
  wire avec_ok  = s_avec && iack_r && !ext_master;
  wire acked    = (|ack_s) || avec_ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= IDLE; cnt <= '0; iack_r <= 1'b0; lvl_r <= '0; rerun <= 1'b0;
      cyc_done <= 1'b0; cyc_port16 <= 1'b0; cyc_avec <= 1'b0;
      cyc_err <= 1'b0; cyc_retry <= 1'b0; vec_valid <= 1'b0; vec_num <= '0;
    end else begin
      cyc_done <= 1'b0; cyc_avec <= 1'b0; cyc_err <= 1'b0;
      cyc_retry <= 1'b0; vec_valid <= 1'b0;
      case (st)
        IDLE:
          if (start && internal) begin
            cyc_done <= 1'b1; cyc_port16 <= 1'b1;
          end else if (start) begin
            st <= RUN; cnt <= '0; iack_r <= iack; lvl_r <= int_level;
          end
        RUN: begin
          cnt <= cnt + 1'b1;
          if (berr_eff && s_halt) begin
            cyc_retry <= 1'b1; st <= HOLD; rerun <= 1'b1;
          end else if (berr_eff) begin
            cyc_err <= 1'b1; st <= IDLE;
          end else if (acked) begin
            cyc_done   <= 1'b1;
            cyc_avec   <= avec_ok;
            cyc_port16 <= avec_ok ? 1'b0 : ack_s[1];
            vec_valid  <= avec_ok;
            if (avec_ok) vec_num <= 8'(VEC_BASE) + {5'd0, lvl_r};
            st <= s_halt ? HOLD : IDLE;
            rerun <= 1'b0;
          end
        end
        default: begin
          if (start && internal) begin
            cyc_done <= 1'b1; cyc_port16 <= 1'b1;
          end
          if (!s_halt) begin
            st <= rerun ? RUN : IDLE; cnt <= '0; rerun <= 1'b0;
          end
        end
      endcase
    end

  assign data_oe   = (st == RUN);
  assign strobe_oe = (st == RUN);
  assign addr_oe   = (st != IDLE);
  assign halted    = (st == HOLD);
  assign irq_mask  = halted;

  p_one_outcome_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cyc_done, cyc_err, cyc_retry}));
  p_timeout_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_err && !$past(s_berr) |-> !$past(ext_master) && $past(cnt) == CW'(TIMEOUT - 1));
  p_retry_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_retry |-> halted && addr_oe && !strobe_oe);
  p_hold_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !data_oe && !strobe_oe && addr_oe);
  p_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask == halted);
  p_vec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> cyc_done && cyc_avec);
  p_vec_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |=> !vec_valid);
  p_extm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> !$past(ext_master));
endmodule

// File: tb/bus_term_ctrl_test.sv
module bus_term_ctrl_test;
  localparam int T = 12;
  localparam int VB = 64;
  logic clk = 0, rst_n = 0;
  logic start = 0, internal = 0, iack = 0, ext_master = 0, avec = 0, berr = 0, halt = 0;
  logic [2:0] int_level = 0;
  logic [1:0] size_ack = 0;
  logic cyc_done, cyc_port16, cyc_avec, cyc_err, cyc_retry, vec_valid;
  logic [7:0] vec_num;
  logic data_oe, strobe_oe, addr_oe, halted, irq_mask;
  int checks = 0, fails = 0, n;

  always #10 clk = ~clk;

  bus_term_ctrl #(.TIMEOUT(T), .VEC_BASE(VB)) uut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clear_inputs();
    size_ack = 0; avec = 0; berr = 0; halt = 0; start = 0; internal = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic launch(input logic ia, input logic [2:0] lv, input logic [1:0] sa,
                        input logic av, input logic be, input logic ha, input int lim);
    @(negedge clk);
    start = 1; iack = ia; int_level = lv; size_ack = sa; avec = av; berr = be; halt = ha;
    n = 0;
    for (int i = 0; i < lim; i++) begin
      @(posedge clk); n++;
      @(negedge clk); start = 0;
      if (cyc_done || cyc_err || cyc_retry) break;
    end
  endtask

  initial begin
    repeat (2) @(negedge clk);
    chk("R11 reset", {cyc_done, cyc_err, cyc_retry, halted, irq_mask, data_oe, strobe_oe, addr_oe}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int sa = 1; sa < 4; sa++) begin
      launch(0, 0, 2'(sa), 0, 0, 0, 20);
      chk("R10 latency", n, 3);
      chk("R9 done", cyc_done, 1);
      chk("R9 width", cyc_port16, (sa >= 2) ? 1 : 0);
      chk("R7 no avec", cyc_avec, 0);
      clear_inputs();
    end

    launch(0, 0, 0, 0, 0, 0, 3*T);
    chk("R1 timeout cycle", n, T + 1);
    chk("R1 err", cyc_err, 1);
    clear_inputs();

    launch(0, 5, 0, 1, 0, 0, 3*T);
    chk("R7 avec ignored outside iack", n, T + 1);
    chk("R7 err", cyc_err, 1);
    chk("R7 no vec", vec_valid, 0);
    clear_inputs();

    for (int lv = 0; lv < 8; lv++) begin
      launch(1, 3'(lv), 0, 1, 0, 0, 20);
      chk("R7 avec done", cyc_done && cyc_avec && vec_valid, 1);
      chk("R7 vec num", vec_num, VB + lv);
      @(negedge clk);
      chk("R7 vec one cycle", vec_valid, 0);
      clear_inputs();
    end

    launch(0, 0, 2'b10, 0, 1, 0, 20);
    chk("R2 err with ack", cyc_err, 1);
    chk("R2 no done", cyc_done, 0);
    clear_inputs();

    ext_master = 1;
    launch(1, 2, 0, 1, 0, 0, 3*T);
    chk("R8 no timeout no avec", cyc_done || cyc_err, 0);
    chk("R8 bus still active", strobe_oe, 1);
    berr = 1;
    repeat (3) @(negedge clk);
    chk("R8 ended by berr", cyc_err, 1);
    ext_master = 0;
    clear_inputs();

    launch(0, 0, 2'b01, 0, 0, 1, 20);
    chk("R4 step done", cyc_done, 1);
    chk("R4 width8", cyc_port16, 0);
    chk("R4 halted", halted, 1);
    repeat (5) @(negedge clk);
    chk("R4 held enables", {data_oe, strobe_oe, addr_oe}, 3'b001);
    chk("R6 mask", irq_mask, 1);
    start = 1; internal = 1;
    @(negedge clk);
    start = 0; internal = 0;
    chk("R5 internal done", cyc_done && cyc_port16, 1);
    chk("R5 still halted", halted, 1);
    halt = 0;
    repeat (3) @(negedge clk);
    chk("R4 released", halted, 0);
    chk("R6 unmask", irq_mask, 0);
    clear_inputs();

    launch(0, 0, 0, 0, 1, 1, 20);
    chk("R3 retry", cyc_retry, 1);
    chk("R3 no err", cyc_err, 0);
    chk("R3 held", halted, 1);
    berr = 0; halt = 0; size_ack = 2'b11;
    n = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (cyc_done || cyc_err) break;
    end
    chk("R3 rerun done", cyc_done, 1);
    chk("R3 rerun width", cyc_port16, 1);
    clear_inputs();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule